// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel port peripheral with three 8-bit ports, A, B and C. Port C is split into an upper and a lower 4-bit half. Each port or half-port is either an output, which drives a latched value, or an input, which is read live from its pins. Every pin is brought out as a separate input value, output value and output enable, so the chip's pad ring can build the tristate drivers.

A host reaches the block over an 8-bit data bus. A 2-bit register select, an active-low chip select and active-high read and write strobes control each access. Four registers are addressed: a data register for each of the three ports and a control register. A control write is decoded in one of two ways by its top bit. It is either a configuration word that sets every port's direction at once, or a command that sets or clears one chosen port C line. Only the basic input/output behaviour is provided. Strobed handshaking and bidirectional transfers are not part of this block.

Top module: `pport_top`

## Requirements
- R1: After reset every output enable is low, so all ports are inputs. Every output value is zero, and a read of the control register returns 0x9B.
- R2: Register select 0 addresses port A, 1 addresses port B, 2 addresses port C and 3 addresses the control register. A write to a data register is captured on the rising clock edge where chip select is low and the write strobe is high. The new value appears on that port's output value pins after that edge, whatever the port's direction.
- R3: A control write with bit 7 = 1, bits 6:5 = 0 and bit 2 = 0 is a configuration word. Bit 4 sets the direction of port A, bit 3 the upper half of C, bit 1 port B and bit 0 the lower half of C, with 1 meaning input. The output enables of a port or half are all high when it is an output and all low when it is an input. A read of the control register returns the last accepted configuration word.
- R4: An accepted configuration word clears all three output latches to zero.
- R5: A control write with bit 7 = 1 and a nonzero value in bits 6:5 or bit 2 is ignored. Directions, latches and the control readback all stay unchanged.
- R6: A control write with bit 7 = 0 changes one port C latch line. The line index is given by bits 3:1 and the new value by bit 0. The other port C lines, ports A and B, and the configuration stay unchanged.
- R7: An output port holds its latched value until the next write to it. A read of an output port returns the latched value.
- R8: A read of an input port returns the live pin values in the same cycle. A write to an input port's data register does not change the read result, and the port's output enables stay low.
- R9: A read of port C returns the latch for each half configured as an output and the live pins for each half configured as an input.
- R10: While chip select is high, writes have no effect, the data output enable is low and the read data is zero.
- R11: The data output enable is high only while chip select is low and the read strobe is high. At all other times the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, zero when not reading |
| dout_oe | output | 1 | High while read data is being driven |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A latched output value |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B latched output value |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C latched output value |
| pc_oe | output | 8 | Port C output enables, upper half bits 7:4 |

## Verification
Register state is updated by the single rising edge that samples a write strobe. The output values, output enables and control readback therefore show the result one edge after the write cycle. The bench drives each write between falling edges and checks at the next falling edge. Read data is combinational, so each read sets its strobe at a falling edge and samples a moment later in that same low phase, with no clock edge between. Pin changes are checked in the same way, with no edge needed.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int SEL_W  = $clog2(DATA_W);
    localparam int ADDR_W = 2;

    // control word field positions
    localparam int CW_FLAG = 7;
    localparam int CW_A    = 4;
    localparam int CW_CHI  = 3;
    localparam int CW_B    = 1;
    localparam int CW_CLO  = 0;
    localparam int SR_VAL  = 0;
    localparam int SR_IDX  = 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic a_in;
        logic chi_in;
        logic b_in;
        logic clo_in;
    } dir_t;

    typedef struct packed {
        logic cfg_wr;
        logic sr_wr;
        logic a_wr;
        logic b_wr;
        logic c_wr;
    } wr_cmd_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};

    function automatic logic cfg_ok(input logic [DATA_W-1:0] w);
        return w[CW_FLAG] && (w[6:5] == 2'b00) && !w[2];
    endfunction

    function automatic dir_t dir_from_word(input logic [DATA_W-1:0] w);
        dir_t d;
        d.a_in   = w[CW_A];
        d.chi_in = w[CW_CHI];
        d.b_in   = w[CW_B];
        d.clo_in = w[CW_CLO];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] word_from_dir(input dir_t d);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[CW_FLAG] = 1'b1;
        w[CW_A]    = d.a_in;
        w[CW_CHI]  = d.chi_in;
        w[CW_B]    = d.b_in;
        w[CW_CLO]  = d.clo_in;
        return w;
    endfunction
endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
(
    input  logic              cs_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctl_flag,
    output wr_cmd_t           cmd
);
    logic wr_en;
    reg_sel_e sel;

    assign wr_en = !cs_n && wr;
    assign sel   = reg_sel_e'(addr);

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            case (sel)
                SEL_A:   cmd.a_wr = 1'b1;
                SEL_B:   cmd.b_wr = 1'b1;
                SEL_C:   cmd.c_wr = 1'b1;
                default: begin
                    cmd.cfg_wr = ctl_flag;
                    cmd.sr_wr  = !ctl_flag;
                end
            endcase
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [DATA_W-1:0] din,
    output dir_t              dir,
    output logic [DATA_W-1:0] a_lat,
    output logic [DATA_W-1:0] b_lat,
    output logic [DATA_W-1:0] c_lat
);
    logic [SEL_W-1:0] sr_idx;
    assign sr_idx = din[SR_IDX +: SEL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir   <= DIR_RESET;
            a_lat <= '0;
            b_lat <= '0;
            c_lat <= '0;
        end else begin
            if (cmd.cfg_wr && cfg_ok(din)) begin
                dir   <= dir_from_word(din);
                a_lat <= '0;
                b_lat <= '0;
                c_lat <= '0;
            end else if (cmd.sr_wr) begin
                c_lat[sr_idx] <= din[SR_VAL];
            end
            if (cmd.a_wr) a_lat <= din;
            if (cmd.b_wr) b_lat <= din;
            if (cmd.c_wr) c_lat <= din;
        end
    end
endmodule

// File: rtl/pport_read.sv
module pport_read
    import pport_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  dir_t              dir,
    input  logic [DATA_W-1:0] a_lat,
    input  logic [DATA_W-1:0] b_lat,
    input  logic [DATA_W-1:0] c_lat,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] c_view;
    logic [DATA_W-1:0] mux;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic half_in;
        assign half_in = (h == 0) ? dir.clo_in : dir.chi_in;
        assign c_view[h*HALF_W +: HALF_W] =
            half_in ? pc_in[h*HALF_W +: HALF_W] : c_lat[h*HALF_W +: HALF_W];
    end

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_A:   mux = dir.a_in ? pa_in : a_lat;
            SEL_B:   mux = dir.b_in ? pb_in : b_lat;
            SEL_C:   mux = c_view;
            default: mux = word_from_dir(dir);
        endcase
    end

    assign dout = rd_en ? mux : '0;
endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    wr_cmd_t cmd;
    dir_t    dir;
    logic [DATA_W-1:0] a_lat, b_lat, c_lat;
    logic rd_en;

    assign rd_en = !cs_n && rd;

    pport_decode u_decode (
        .cs_n     (cs_n),
        .wr       (wr),
        .addr     (addr),
        .ctl_flag (din[CW_FLAG]),
        .cmd      (cmd)
    );

    pport_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .din   (din),
        .dir   (dir),
        .a_lat (a_lat),
        .b_lat (b_lat),
        .c_lat (c_lat)
    );

    pport_read u_read (
        .rd_en (rd_en),
        .addr  (addr),
        .dir   (dir),
        .a_lat (a_lat),
        .b_lat (b_lat),
        .c_lat (c_lat),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .dout  (dout)
    );

    assign dout_oe = rd_en;
    assign pa_out  = a_lat;
    assign pb_out  = b_lat;
    assign pc_out  = c_lat;
    assign pa_oe   = {DATA_W{~dir.a_in}};
    assign pb_oe   = {DATA_W{~dir.b_in}};
    assign pc_oe   = {{HALF_W{~dir.chi_in}}, {HALF_W{~dir.clo_in}}};
endmodule

// File: rtl/pport_chk.sv
module pport_chk
    import pport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] pc_oe
);
    logic ctl_wr;
    assign ctl_wr = !cs_n && wr && (addr == 2'd3);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                        pa_out == '0 && pb_out == '0 && pc_out == '0)); // R1

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1) &&
        (pc_oe[7:4] == '0 || pc_oe[7:4] == '1) &&
        (pc_oe[3:0] == '0 || pc_oe[3:0] == '1)); // R3

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && din[7] && din[6:5] == 2'b00 && !din[2]) |=>
        (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R4

    AST_BAD_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && din[7] && (din[6:5] != 2'b00 || din[2])) |=>
        ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
         $stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R5

    AST_SR_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !din[7]) |=>
        ($countones(pc_out ^ $past(pc_out)) <= 1 &&
         pc_out[$past(din[3:1])] == $past(din[0]) &&
         $stable(pa_out) && $stable(pc_oe))); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(!cs_n && wr) |=>
        ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R7

    AST_CS_NO_READ: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!dout_oe && dout == '0)); // R10

    AST_CS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                  $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R10

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0); // R11
endmodule

bind pport_top pport_chk u_chk (.*);

// File: tb/pport_top_test.sv
module pport_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    pport_top uut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic csn, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = csn; wr = 1'b1; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_cycle(1'b0, a, d);
    endtask

    task automatic bus_read(input logic csn, input logic [1:0] a,
                            output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = csn; rd = 1'b1; addr = a;
        #2;
        d = dout; oe = dout_oe;
        cs_n = 1'b1; rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 pa_out", pa_out, 8'h00);
        check("R1 pc_out", pc_out, 8'h00);
        bus_read(1'b0, 2'd3, d, oe);
        check("R1 ctl readback", d, 8'h9B);
        check("R11 oe during read", {7'd0, oe}, 8'h01);
        #1 check("R11 idle oe", {7'd0, dout_oe}, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d; logic oe;
        bus_write(2'd3, 8'h80);
        check("R3 pa_oe all out", pa_oe, 8'hFF);
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'h22);
        bus_write(2'd2, 8'h33);
        check("R2 pa_out", pa_out, 8'h11);
        check("R2 pb_out", pb_out, 8'h22);
        check("R2 pc_out", pc_out, 8'h33);
        bus_read(1'b0, 2'd0, d, oe); check("R7 read A latch", d, 8'h11);
        bus_read(1'b0, 2'd1, d, oe); check("R7 read B latch", d, 8'h22);
        bus_read(1'b0, 2'd2, d, oe); check("R7 read C latch", d, 8'h33);
        repeat (5) @(negedge clk);
        check("R7 hold A", pa_out, 8'h11);
        check("R7 hold C", pc_out, 8'h33);
    endtask

    task automatic t_cfg_clear();
        bus_write(2'd3, 8'h80);
        check("R4 clear A", pa_out, 8'h00);
        check("R4 clear B", pb_out, 8'h00);
        check("R4 clear C", pc_out, 8'h00);
    endtask

    task automatic t_setreset();
        logic [7:0] d; logic oe;
        bus_write(2'd0, 8'h77);
        bus_write(2'd3, 8'h0F); check("R6 set line7", pc_out, 8'h80);
        bus_write(2'd3, 8'h01); check("R6 set line0", pc_out, 8'h81);
        bus_write(2'd3, 8'h0E); check("R6 clear line7", pc_out, 8'h01);
        bus_write(2'd3, 8'h07); check("R6 set line3", pc_out, 8'h09);
        check("R6 port A untouched", pa_out, 8'h77);
        check("R6 pc_oe untouched", pc_oe, 8'hFF);
        bus_read(1'b0, 2'd3, d, oe);
        check("R6 config untouched", d, 8'h80);
    endtask

    task automatic t_bad_cfg();
        logic [7:0] d; logic oe;
        bus_write(2'd3, 8'hA0);
        check("R5 mode bits oe", pa_oe, 8'hFF);
        check("R5 mode bits latch", pc_out, 8'h09);
        bus_write(2'd3, 8'h84);
        check("R5 bit2 latch A", pa_out, 8'h77);
        check("R5 bit2 pc_oe", pc_oe, 8'hFF);
        bus_read(1'b0, 2'd3, d, oe);
        check("R5 ctl readback", d, 8'h80);
    endtask

    task automatic t_chip_select();
        logic [7:0] d; logic oe;
        bus_cycle(1'b1, 2'd0, 8'hFF);
        check("R10 write ignored", pa_out, 8'h77);
        bus_cycle(1'b1, 2'd3, 8'h9B);
        check("R10 cfg ignored", pa_oe, 8'hFF);
        bus_read(1'b1, 2'd0, d, oe);
        check("R10 read data zero", d, 8'h00);
        check("R10 read oe low", {7'd0, oe}, 8'h00);
    endtask

    task automatic t_strobe_oe();
        @(negedge clk);
        cs_n = 1'b0; rd = 1'b0; addr = 2'd0;
        #2 check("R11 no strobe oe", {7'd0, dout_oe}, 8'h00);
        check("R11 no strobe data", dout, 8'h00);
        rd = 1'b1;
        #2 check("R11 strobe oe", {7'd0, dout_oe}, 8'h01);
        check("R11 strobe data", dout, 8'h77);
        cs_n = 1'b1; rd = 1'b0;
    endtask

    task automatic t_dirs_inputs();
        logic [7:0] d; logic oe;
        bus_write(2'd3, 8'h92);
        check("R3 A input oe", pa_oe, 8'h00);
        check("R3 B input oe", pb_oe, 8'h00);
        check("R3 C output oe", pc_oe, 8'hFF);
        bus_read(1'b0, 2'd3, d, oe); check("R3 readback 92", d, 8'h92);
        pa_in = 8'h5A;
        bus_read(1'b0, 2'd0, d, oe); check("R8 live A 5A", d, 8'h5A);
        pa_in = 8'hA5;
        bus_read(1'b0, 2'd0, d, oe); check("R8 live A A5", d, 8'hA5);
        pb_in = 8'h3E;
        bus_read(1'b0, 2'd1, d, oe); check("R8 live B", d, 8'h3E);
        bus_write(2'd0, 8'h66);
        bus_read(1'b0, 2'd0, d, oe); check("R8 write to input", d, 8'hA5);
        check("R8 input oe stays low", pa_oe, 8'h00);
        check("R2 latch on input port", pa_out, 8'h66);
        bus_write(2'd3, 8'h89);
        check("R3 C both in", pc_oe, 8'h00);
        check("R3 A out", pa_oe, 8'hFF);
        bus_write(2'd3, 8'h88);
        check("R3 C upper in", pc_oe, 8'h0F);
    endtask

    task automatic t_portc_mix();
        logic [7:0] d; logic oe;
        bus_write(2'd2, 8'h3C);
        pc_in = 8'hA5;
        check("R2 pc_out", pc_out, 8'h3C);
        bus_read(1'b0, 2'd2, d, oe); check("R9 mixed C read", d, 8'hAC);
        bus_write(2'd3, 8'h81);
        bus_write(2'd2, 8'h3C);
        bus_read(1'b0, 2'd2, d, oe); check("R9 lower in C read", d, 8'h35);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_cfg_clear();
        t_setreset();
        t_bad_cfg();
        t_chip_select();
        t_strobe_oe();
        t_dirs_inputs();
        t_portc_mix();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule